// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Engine

This block is the bus-facing side of a byte-wide serial memory that answers on a two-wire bus. A fast system clock oversamples the clock and data lines. Each line passes through a synchroniser and a small glitch filter, and the filtered levels are then decoded into start conditions, stop conditions and data bits. Each transaction opens with an address byte. When the byte selects this target, it is followed either by a two-byte word address and data bytes (write) or by data that the target shifts out (read). The storage is a parameterised register array inside the block.

A single address counter survives between transactions. On writes it steps only within the current 128-byte page. On reads it steps through the whole array and wraps to byte 0. For a timed interval after any write transaction the target stays deaf, refusing to acknowledge its own address, so a master can poll it until it answers. The data line is never driven high: the block only asserts a pull-low enable.

Top module: `twmem_target`

## Requirements
- R1: A falling data line while the clock line is high is a start condition, and a rising data line while the clock is high is a stop. A start in any state abandons the transfer in progress and begins address reception. A stop returns the target to idle. An abandoned transfer leaves the address counter unchanged.
- R2: The address byte is sent MSB first. Bits 7..4 must be 1010 and bits 3..1 must equal `strap_i[2:0]` in that order. Bit 0 is the direction, with 1 meaning read. On a mismatch the target gives no acknowledge and ignores every byte until the next start.
- R3: The target acknowledges every accepted byte it receives (address, word address, write data) by pulling the data line low for the whole ninth clock.
- R4: After a write-direction address byte, two word-address bytes follow, high byte first. The low `ADDR_W` bits of the 16-bit value load the address counter, so higher bits are dropped.
- R5: Each write data byte is stored at the counter. The counter then advances in its low 7 bits only, so the byte after the last one of a 128-byte page goes to the first byte of the same page.
- R6: A read-direction address byte with no preceding word address returns the byte at the counter, which holds the last accessed address plus one. The counter persists across transactions.
- R7: A random read is a write-direction address byte and two word-address bytes with no data, then a repeated start and a read-direction address byte. It returns the byte at the supplied address.
- R8: During a read, each master acknowledge sends the next byte. The counter steps across the whole array and wraps from the last byte to byte 0. A missing acknowledge ends the read.
- R9: While `wp_i` is 1, write data bytes are still acknowledged but the array is not changed.
- R10: After a stop that ends a transaction containing at least one write data byte, the target acknowledges no address byte for `WR_CYCLES` system clocks.
- R11: Read data is shifted out MSB first. The pull-low enable changes only after a falling clock edge has been detected, never while the clock line is high.
- R12: The data line output is a pull-low enable only. It is 0 out of reset and whenever the target is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_pull_o | output | 1 | 1 pulls the data line low; 0 releases it |
| strap_i | input | 3 | Board-strapped selection bits compared with address bits 3..1 |
| wp_i | input | 1 | 1 blocks all array writes |

## Verification
The assertions assume that the bus master changes the data line only while the clock line is low, except when it makes a start or a stop. They also assume that every bus clock phase lasts longer than the six-cycle filter latency plus one register, and that the strap inputs do not change during a transaction. The bench master holds each clock phase for 16 system clocks and moves data at the middle of the low phase. It never issues a start or stop while the target is pulling the line low, and it ends every read with a missing acknowledge before the stop.

// File: rtl/twmem_pkg.sv
package twmem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WR,
    ST_RD
  } tw_state_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/twmem_filter.sv
module twmem_filter #(
  parameter int LINES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] clean_o
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [1:0] sync_q;
    logic [2:0] hist_q;
    logic       lvl_q, lvl_d;

    always_comb begin
      lvl_d = lvl_q;
      if (hist_q == 3'b000)      lvl_d = 1'b0;
      else if (hist_q == 3'b111) lvl_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= 2'b11;
        hist_q <= 3'b111;
        lvl_q  <= 1'b1;
      end else begin
        sync_q <= {sync_q[0], raw_i[i]};
        hist_q <= {hist_q[1:0], sync_q[1]};
        lvl_q  <= lvl_d;
      end
    end

    assign clean_o[i] = lvl_q;
  end
endmodule

// File: rtl/twmem_store.sv
module twmem_store #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) cells[waddr_i] <= wdata_i;
  end

  assign rdata_o = cells[raddr_i];
endmodule

// File: rtl/twmem_engine.sv
module twmem_engine
  import twmem_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int PAGE_W    = 7,
  parameter int WR_CYCLES = 600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic [2:0]        strap_i,
  input  logic              wp_i,
  input  logic [7:0]        mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  output logic              sda_pull
);
  localparam int BUSY_W = $clog2(WR_CYCLES + 1);

  tw_state_e         state_q, state_d;
  logic [3:0]        bit_q, bit_d;
  logic [7:0]        sh_q, sh_d, hi_q, hi_d;
  logic              ack_q, ack_d, pull_q, pull_d, rw_q, rw_d;
  logic              mack_q, mack_d, wrote_q, wrote_d;
  logic              scl_q, sda_q;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BUSY_W-1:0] busy_q, busy_d;
  logic              scl_rise, scl_fall, start_ev, stop_ev;

  assign scl_rise = scl_lvl & ~scl_q;
  assign scl_fall = ~scl_lvl & scl_q;
  assign start_ev = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_ev  = scl_lvl & scl_q & ~sda_q & sda_lvl;

  always_comb begin
    state_d = state_q;  bit_d  = bit_q;   sh_d   = sh_q;   hi_d    = hi_q;
    ack_d   = ack_q;    pull_d = pull_q;  rw_d   = rw_q;   mack_d  = mack_q;
    addr_d  = addr_q;   wrote_d = wrote_q; mem_we = 1'b0;
    busy_d  = (busy_q != '0) ? busy_q - BUSY_W'(1) : busy_q;
    if (start_ev) begin
      state_d = ST_DEV; bit_d = '0; ack_d = 1'b0; pull_d = 1'b0;
    end else if (stop_ev) begin
      state_d = ST_IDLE; bit_d = '0; ack_d = 1'b0; pull_d = 1'b0;
      if (wrote_q) begin
        busy_d  = BUSY_W'(WR_CYCLES);
        wrote_d = 1'b0;
      end
    end else if (state_q == ST_RD) begin
      if (ack_q) begin
        if (scl_rise) mack_d = ~sda_lvl;
        else if (scl_fall) begin
          ack_d = 1'b0; bit_d = '0;
          if (mack_q) begin
            sh_d = mem_rdata; pull_d = ~mem_rdata[7]; addr_d = addr_q + 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end else if (scl_fall) begin
        if (bit_q == 4'd7) begin
          pull_d = 1'b0; ack_d = 1'b1; mack_d = 1'b0;
        end else begin
          sh_d = {sh_q[6:0], 1'b0}; pull_d = ~sh_q[6]; bit_d = bit_q + 4'd1;
        end
      end
    end else if (state_q != ST_IDLE) begin
      if (ack_q) begin
        if (scl_fall) begin
          ack_d = 1'b0; pull_d = 1'b0; bit_d = '0;
          case (state_q)
            ST_DEV: if (rw_q) begin
                      state_d = ST_RD; sh_d = mem_rdata;
                      pull_d = ~mem_rdata[7]; addr_d = addr_q + 1'b1;
                    end else state_d = ST_AHI;
            ST_AHI: state_d = ST_ALO;
            ST_ALO: state_d = ST_WR;
            default: state_d = state_q;
          endcase
        end
      end else if (scl_rise && bit_q != 4'd8) begin
        sh_d = {sh_q[6:0], sda_lvl}; bit_d = bit_q + 4'd1;
      end else if (scl_fall && bit_q == 4'd8) begin
        case (state_q)
          ST_DEV: if (sh_q[7:4] == DEV_CODE && sh_q[3:1] == strap_i && busy_q == '0) begin
                    ack_d = 1'b1; pull_d = 1'b1; rw_d = sh_q[0];
                  end else state_d = ST_IDLE;
          ST_AHI: begin hi_d = sh_q; ack_d = 1'b1; pull_d = 1'b1; end
          ST_ALO: begin addr_d = ADDR_W'({hi_q, sh_q}); ack_d = 1'b1; pull_d = 1'b1; end
          default: begin
            ack_d = 1'b1; pull_d = 1'b1; wrote_d = 1'b1; mem_we = ~wp_i;
            addr_d = {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + 1'b1};
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; bit_q  <= '0;   sh_q   <= '0;   hi_q    <= '0;
      ack_q   <= 1'b0;    pull_q <= 1'b0; rw_q   <= 1'b0; mack_q  <= 1'b0;
      addr_q  <= '0;      wrote_q <= 1'b0; busy_q <= '0;
      scl_q   <= 1'b1;    sda_q  <= 1'b1;
    end else begin
      state_q <= state_d; bit_q  <= bit_d;  sh_q   <= sh_d;   hi_q    <= hi_d;
      ack_q   <= ack_d;   pull_q <= pull_d; rw_q   <= rw_d;   mack_q  <= mack_d;
      addr_q  <= addr_d;  wrote_q <= wrote_d; busy_q <= busy_d;
      scl_q   <= scl_lvl; sda_q  <= sda_lvl;
    end
  end

  assign mem_addr  = addr_q;
  assign mem_wdata = sh_q;
  assign sda_pull  = pull_q;

  assert_pull_in_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_q) |-> !scl_lvl);
  assert_ack_on_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DEV && ack_q) |-> (sh_q[7:1] == {DEV_CODE, strap_i}));
  assert_deaf_when_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DEV && ack_q) |-> (busy_q == '0));
  assert_page_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (addr_q[ADDR_W-1:PAGE_W] == $past(addr_q[ADDR_W-1:PAGE_W])));
  assert_idle_released_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !pull_q);
endmodule

// File: rtl/twmem_target.sv
module twmem_target #(
  parameter int ADDR_W    = 10,
  parameter int PAGE_W    = 7,
  parameter int WR_CYCLES = 600
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic [2:0] strap_i,
  input  logic       wp_i
);
  logic [1:0]        rst_sync_q;
  logic              core_rst_n;
  logic [1:0]        lines_clean;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_we;
  logic [7:0]        mem_wdata, mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  twmem_filter #(.LINES(2)) u_filter (
    .clk(clk), .rst_n(core_rst_n),
    .raw_i({sda_i, scl_i}), .clean_o(lines_clean)
  );

  twmem_engine #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_engine (
    .clk(clk), .rst_n(core_rst_n),
    .scl_lvl(lines_clean[0]), .sda_lvl(lines_clean[1]),
    .strap_i(strap_i), .wp_i(wp_i),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .sda_pull(sda_pull_o)
  );

  twmem_store #(.ADDR_W(ADDR_W), .DATA_W(8)) u_store (
    .clk(clk), .we_i(mem_we), .waddr_i(mem_addr), .wdata_i(mem_wdata),
    .raddr_i(mem_addr), .rdata_o(mem_rdata)
  );

  assert_no_write_protected_R9: assert property (@(posedge clk) disable iff (!core_rst_n)
    mem_we |-> !wp_i);
endmodule

// File: tb/twmem_target_tb.sv
`timescale 1ns/1ps
module twmem_target_tb;
  localparam int AW    = 10;
  localparam int WRC   = 600;
  localparam int H     = 16;
  localparam int DEPTH = 1 << AW;

  logic       clk = 1'b0;
  logic       rst_n, scl_m, sda_m, wp;
  logic [2:0] strap;
  logic       sda_pull;
  wire        sda_line = sda_m & ~sda_pull;

  int vectors = 0;
  int fails   = 0;
  int mdata [DEPTH];
  int maddr = 0;
  logic prev_pull = 1'b0;

  always #2.5 clk = ~clk;

  twmem_target #(.ADDR_W(AW), .PAGE_W(7), .WR_CYCLES(WRC)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .strap_i(strap), .wp_i(wp)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // R11: pull-low enable only changes while the raw clock line is low
  always @(negedge clk) begin
    if (rst_n && sda_pull !== prev_pull) check(scl_m == 1'b0, "R11", scl_m, 0);
    prev_pull = sda_pull;
  end

  task automatic bus_start();
    sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(H); sda_m = 1'b0; tick(H); scl_m = 1'b0; tick(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(H); scl_m = 1'b1; tick(H); sda_m = 1'b1; tick(H);
  endtask

  task automatic bit_xfer(input bit b, output bit r);
    tick(H/2); sda_m = b; tick(H/2); scl_m = 1'b1; tick(H-1); r = sda_line; tick(1); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    bit r;
    for (int i = 7; i >= 0; i--) bit_xfer(b[i], r);
    bit_xfer(1'b1, r);
    acked = !r;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    bit r;
    for (int i = 7; i >= 0; i--) begin bit_xfer(1'b1, r); d[i] = r; end
    bit_xfer(!mack, r);
  endtask

  function automatic logic [7:0] dev_byte(input bit rd);
    return {4'b1010, strap, rd};
  endfunction

  task automatic set_addr(input logic [15:0] wa);
    bit a;
    bus_start();
    send_byte(dev_byte(1'b0), a); check(a, "R2", a, 1);
    send_byte(wa[15:8], a);       check(a, "R4", a, 1);
    send_byte(wa[7:0], a);        check(a, "R4", a, 1);
    maddr = int'(wa) & (DEPTH - 1);
  endtask

  task automatic wr_seq(input logic [15:0] wa, input logic [7:0] q[$]);
    bit a;
    set_addr(wa);
    foreach (q[k]) begin
      send_byte(q[k], a); check(a, "R3", a, 1);
      if (!wp) mdata[maddr] = int'(q[k]);
      maddr = (maddr & ~127) | ((maddr + 1) & 127);
    end
    bus_stop();
  endtask

  task automatic rd_cur(input int n, input string req);
    bit a;
    logic [7:0] d;
    bus_start();
    send_byte(dev_byte(1'b1), a); check(a, "R3", a, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, d);
      check(mdata[maddr] < 0 || int'(d) == mdata[maddr], req, d, mdata[maddr]);
      maddr = (maddr + 1) % DEPTH;
    end
    bus_stop();
  endtask

  task automatic settle();
    tick(WRC + 100);
  endtask

  initial begin
    bit a;
    for (int i = 0; i < DEPTH; i++) mdata[i] = -1;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; wp = 1'b0; strap = 3'b101;
    tick(5);
    check(sda_pull == 1'b0, "R12", sda_pull, 0);
    rst_n = 1'b1;
    tick(10);
    check(sda_pull == 1'b0, "R12", sda_pull, 0);

    // R3 R4: write five bytes, then R7 random read and R8 sequential read
    wr_seq(16'h0010, '{8'h3C, 8'hA5, 8'h01, 8'hFE, 8'h77});
    settle();
    set_addr(16'h0010);
    rd_cur(4, "R8");
    // R6: current-address read continues at 0x0014
    rd_cur(1, "R6");
    set_addr(16'h0012);
    rd_cur(1, "R7");

    // R5: page roll-over inside page 0, page 1 untouched
    wr_seq(16'h0080, '{8'h5A});
    settle();
    wr_seq(16'h007E, '{8'h11, 8'h22, 8'h33});
    settle();
    set_addr(16'h007E);
    rd_cur(3, "R5");
    set_addr(16'h0000);
    rd_cur(1, "R5");

    // R8 and R4: array wrap from last byte to byte 0, upper address bits dropped
    wr_seq(16'hFFFF, '{8'hC9});
    settle();
    set_addr(16'hFFFF);
    rd_cur(2, "R8");

    // R2: mismatched strap bits get no acknowledge, later bytes ignored
    bus_start();
    send_byte({4'b1010, 3'b011, 1'b0}, a); check(!a, "R2", a, 0);
    send_byte(8'h00, a);                   check(!a, "R2", a, 0);
    bus_stop();
    check(sda_pull == 1'b0, "R12", sda_pull, 0);

    // R10: target is deaf right after a write, answers later
    wr_seq(16'h0040, '{8'h9D});
    bus_start();
    send_byte(dev_byte(1'b0), a); check(!a, "R10", a, 0);
    bus_stop();
    settle();
    bus_start();
    send_byte(dev_byte(1'b0), a); check(a, "R10", a, 1);
    bus_stop();

    // R9: protected write is acknowledged but leaves the array alone
    wp = 1'b1;
    wr_seq(16'h0010, '{8'hEE});
    settle();
    wp = 1'b0;
    set_addr(16'h0010);
    rd_cur(1, "R9");

    // R1: start inside the word-address phase abandons it; counter unchanged
    set_addr(16'h0040);
    rd_cur(1, "R6");
    bus_start();
    send_byte(dev_byte(1'b0), a); check(a, "R1", a, 1);
    send_byte(8'h02, a);          check(a, "R1", a, 1);
    rd_cur(1, "R1");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule